// File: doc/BRIEF.md
# Muted Audio Clock Source Switch

This block picks one of two free-running audio master clocks and passes it to a single output. One source belongs to the 44.1 kHz sample-rate family and the other to the 48 kHz family. A rate-select pin, which may change at any time and with no relation to any clock, chooses between them. Whenever the effective selection changes, in either direction, the output is parked low for a bounded time. It then restarts cleanly from the newly chosen source, so the downstream audio converters never see a shortened pulse or a spike.

The mute is timed by a free-running reference clock. Its length in reference cycles is derived at elaboration time from the reference frequency, the slowest source frequency and the synchronizer depth. The derivation keeps the time from a select change to the first full pulse of the new source within 1 µs. A polarity strap swaps the meaning of the select pin, and an enable strap turns the mute off. A build-time parameter removes the select path entirely, and that build always drives the first source.

Each source clock is gated inside its own domain. The gate can only open or close while that source is low, so every pulse that leaves the block is a full-width pulse of one source.

Top module: `audclk_mute_sel`

## Requirements
- R1: With `mute_en` high, a change of the effective selection (`sel_pin` XOR `swap_pol`) in either direction, rising or falling, starts a mute.
- R2: During a mute, `clk_out` stays low. Once the last full pulse of the old source has ended, no edge appears until the new source starts. Every high pulse on `clk_out` is a full high phase of one source, never a shortened one.
- R3: The mute lasts at most MUTE_CYC reference cycles. With default parameters (50 MHz reference, sources no slower than 11 MHz), the first rising edge of the new source on `clk_out` comes no more than 1000 ns after the `sel_pin` change.
- R4: When a mute ends, `clk_out` follows the source given by the effective selection at that moment.
- R5: With `swap_pol` low, effective selection 0 (`sel_pin` low) drives `clk_a`, the 44.1 kHz-family source, and effective selection 1 drives `clk_b`, the 48 kHz-family source. With `swap_pol` high the mapping is reversed. A change of `swap_pol` counts as a selection change.
- R6: With `mute_en` low, no mute occurs. A selection change hands over to the new source after only the synchronizer delays, with no low gap longer than 150 ns.
- R7: With HAS_SEL = 0, `clk_out` is always `clk_a`, and `sel_pin` and `swap_pol` have no effect.
- R8: While `rst` is high, `clk_out` is low. With `mute_en` high, `clk_out` stays low for a full mute interval after `rst` falls, then starts the selected source within 1000 ns of the release.
- R9: A selection change that arrives during a mute restarts the mute count from its full length. The output then resumes from the last synchronized level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Free-running reference clock that times the mute |
| rst | input | 1 | Synchronous active-high reset |
| clk_a | input | 1 | 44.1 kHz-family master clock source |
| clk_b | input | 1 | 48 kHz-family master clock source |
| sel_pin | input | 1 | Asynchronous rate-select pin |
| swap_pol | input | 1 | Strap that reverses the select mapping |
| mute_en | input | 1 | Strap that enables muting on selection changes |
| clk_out | output | 1 | Gated audio master clock |

## Verification
Two functions can fall in the same reference cycle: a new selection change and the last cycle of a running mute. The outcome must be a restart of the full mute, not a release onto the stale source. A directed double toggle places the second change partway into the mute. Constrained-random bursts of one to three toggles with random spacing sweep the second change across every mute cycle, including its final one. In each case the bench checks three things: the output's period after settling matches the final level, the end of the last low gap lies within 1000 ns of the last toggle, and later than a non-restarted mute would allow. A pulse-width monitor confirms that no shortened high pulse ever appears.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
  localparam int NSRC = 2;

  // Reference cycles of mute such that synchronizer latency, mute and the
  // hand-on delay in the slowest source domain fit inside the time limit.
  function automatic int mute_cycles(int ref_mhz, int lim_ns, int src_min_mhz, int sync_n);
    int total;
    int hand_on;
    total   = (ref_mhz * lim_ns) / 1000;
    hand_on = ((sync_n + 1) * ref_mhz + src_min_mhz - 1) / src_min_mhz;
    return total - (sync_n + 1) - hand_on;
  endfunction
endpackage

// File: rtl/audclk_sync.sv
module audclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/audclk_mute_timer.sv
module audclk_mute_timer #(
  parameter int MUTE_CYC = 33,
  parameter int CW       = 6
) (
  input  logic       clk_ref,
  input  logic       rst,
  input  logic       feat_en,
  input  logic       sel_eff,
  output logic       mute,
  output logic [1:0] want
);
  logic          held;
  logic [CW-1:0] cnt;
  logic          held_n;
  logic          mute_n;
  logic [CW-1:0] cnt_n;
  logic          change;

  assign change = (sel_eff != held);

  always_comb begin
    held_n = held;
    mute_n = mute;
    cnt_n  = cnt;
    if (change) held_n = sel_eff;
    if (!feat_en) begin
      mute_n = 1'b0;
      cnt_n  = '0;
    end else if (change) begin
      mute_n = 1'b1;
      cnt_n  = CW'(MUTE_CYC);
    end else if (cnt != '0) begin
      cnt_n = cnt - CW'(1);
      if (cnt == CW'(1)) mute_n = 1'b0;
    end
  end

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      held <= sel_eff;
      mute <= feat_en;
      cnt  <= feat_en ? CW'(MUTE_CYC) : '0;
      want <= feat_en ? 2'b00 : {sel_eff, !sel_eff};
    end else begin
      held <= held_n;
      mute <= mute_n;
      cnt  <= cnt_n;
      want <= {held_n & !mute_n, !held_n & !mute_n};
    end
  end
endmodule

// File: rtl/audclk_fall_gate.sv
module audclk_fall_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_src,
  input  logic rst,
  input  logic want,
  output logic gclk
);
  logic want_s;
  logic en;

  audclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk_src),
    .rst (rst),
    .d   (want),
    .q   (want_s)
  );

  // Enable moves only while the source is low, so pulses stay whole.
  always_ff @(negedge clk_src) begin
    if (rst) en <= 1'b0;
    else     en <= want_s;
  end

  assign gclk = clk_src & en;
endmodule

// File: rtl/audclk_mute_sel.sv
module audclk_mute_sel
  import audclk_pkg::*;
#(
  parameter int REF_MHZ     = 50,
  parameter int LIMIT_NS    = 1000,
  parameter int SRC_MIN_MHZ = 11,
  parameter int SYNC_STAGES = 2,
  parameter bit HAS_SEL     = 1'b1
) (
  input  logic clk_ref,
  input  logic rst,
  input  logic clk_a,
  input  logic clk_b,
  input  logic sel_pin,
  input  logic swap_pol,
  input  logic mute_en,
  output logic clk_out
);
  localparam int MUTE_CYC = mute_cycles(REF_MHZ, LIMIT_NS, SRC_MIN_MHZ, SYNC_STAGES);
  localparam int CW       = $clog2(MUTE_CYC + 1);

  logic            sel_sync;
  logic            sel_eff;
  logic            mute;
  logic [NSRC-1:0] want;
  logic [NSRC-1:0] src;
  logic [NSRC-1:0] gated;

  assign src = {clk_b, clk_a};

  generate
    if (HAS_SEL) begin : g_sel
      audclk_sync #(.STAGES(SYNC_STAGES)) u_sel_sync (
        .clk (clk_ref),
        .rst (rst),
        .d   (sel_pin),
        .q   (sel_sync)
      );
      assign sel_eff = sel_sync ^ swap_pol;
      audclk_mute_timer #(.MUTE_CYC(MUTE_CYC), .CW(CW)) u_timer (
        .clk_ref (clk_ref),
        .rst     (rst),
        .feat_en (mute_en),
        .sel_eff (sel_eff),
        .mute    (mute),
        .want    (want)
      );
    end else begin : g_fixed
      assign sel_sync = 1'b0;
      assign sel_eff  = 1'b0;
      assign mute     = 1'b0;
      assign want     = 2'b01;
    end
  endgenerate

  for (genvar i = 0; i < NSRC; i++) begin : g_gate
    audclk_fall_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk_src (src[i]),
      .rst     (rst),
      .want    (want[i]),
      .gclk    (gated[i])
    );
  end

  assign clk_out = |gated;
endmodule

// File: rtl/audclk_mute_chk.sv
module audclk_mute_chk
  import audclk_pkg::*;
#(
  parameter int REF_MHZ     = 50,
  parameter int LIMIT_NS    = 1000,
  parameter int SRC_MIN_MHZ = 11,
  parameter int SYNC_STAGES = 2
) (
  input logic       clk_ref,
  input logic       rst,
  input logic       mute_en,
  input logic       sel_eff,
  input logic       mute,
  input logic [1:0] want
);
  localparam int MUTE_CYC = mute_cycles(REF_MHZ, LIMIT_NS, SRC_MIN_MHZ, SYNC_STAGES);

  logic sel_d;
  int   run;

  always_ff @(posedge clk_ref) begin
    sel_d <= sel_eff;
    if (rst)                   run <= 0;
    else if (sel_eff != sel_d) run <= 0;
    else if (mute)             run <= run + 1;
    else                       run <= 0;
  end

  AST_CHANGE_MUTES: assert property (@(posedge clk_ref) disable iff (rst)
    (mute_en && (sel_eff != sel_d)) |=> mute); // R1

  AST_MUTE_BOUNDED: assert property (@(posedge clk_ref) disable iff (rst)
    mute |-> (run < MUTE_CYC)); // R3

  AST_RELEASE_LEVEL: assert property (@(posedge clk_ref) disable iff (rst)
    $fell(mute) |-> (want[1] == sel_d) && (want[0] == !sel_d)); // R4

  AST_STRAP_OFF: assert property (@(posedge clk_ref) disable iff (rst)
    !mute_en |=> !mute); // R6
endmodule

bind audclk_mute_sel audclk_mute_chk #(
  .REF_MHZ(REF_MHZ), .LIMIT_NS(LIMIT_NS),
  .SRC_MIN_MHZ(SRC_MIN_MHZ), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk_ref (clk_ref),
  .rst     (rst),
  .mute_en (mute_en),
  .sel_eff (sel_eff),
  .mute    (mute),
  .want    (want)
);

// File: tb/sim_audclk_mute_sel.sv
`timescale 1ns/1ps
module sim_audclk_mute_sel;
  logic clk_ref = 1'b0;
  logic clk_a   = 1'b0;
  logic clk_b   = 1'b0;
  logic rst     = 1'b1;
  logic sel     = 1'b0;
  logic swap    = 1'b0;
  logic men     = 1'b1;
  logic out0;
  logic out1;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10   clk_ref = ~clk_ref;
  always #44   clk_a   = ~clk_a;
  always #40.5 clk_b   = ~clk_b;

  audclk_mute_sel u0 (
    .clk_ref(clk_ref), .rst(rst), .clk_a(clk_a), .clk_b(clk_b),
    .sel_pin(sel), .swap_pol(swap), .mute_en(men), .clk_out(out0)
  );

  audclk_mute_sel #(.HAS_SEL(1'b0)) u1 (
    .clk_ref(clk_ref), .rst(rst), .clk_a(clk_a), .clk_b(clk_b),
    .sel_pin(sel), .swap_pol(swap), .mute_en(men), .clk_out(out1)
  );

  // output monitor: long low gaps and high pulse widths
  realtime t_rise = 0.0;
  realtime t_fall = 0.0;
  realtime gap_end = 0.0;
  realtime gap_len = 0.0;
  int      long_gaps = 0;
  int      runts = 0;
  bit      runt_en = 1'b1;

  always @(posedge out0) begin
    if ($realtime - t_fall > 150.0) begin
      long_gaps++;
      gap_end = $realtime;
      gap_len = $realtime - t_fall;
    end
    t_rise = $realtime;
  end

  always @(negedge out0) begin
    if (runt_en && (($realtime - t_rise) < 39.0 || ($realtime - t_rise) > 45.5)) runts++;
    t_fall = $realtime;
  end

  function automatic real exp_period(bit s, bit sw);
    return (s ^ sw) ? 81.0 : 88.0;
  endfunction

  task automatic check(bit ok, string req, real act, real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0.2f expected=%0.2f", req, act, exp);
    end
  endtask

  task automatic meas0(output real p);
    realtime t0;
    @(posedge out0); t0 = $realtime;
    @(posedge out0); p = $realtime - t0;
  endtask

  task automatic meas1(output real p);
    realtime t0;
    @(posedge out1); t0 = $realtime;
    @(posedge out1); p = $realtime - t0;
  endtask

  task automatic check_period(string req);
    real p;
    real e;
    e = exp_period(sel, swap);
    meas0(p);
    check((p > e - 0.6) && (p < e + 0.6), req, p, e);
  endtask

  // one selection change with mute on
  task automatic switch_to(bit new_sel, bit new_swap, string req);
    realtime tt;
    long_gaps = 0;
    tt = $realtime;
    sel  = new_sel;
    swap = new_swap;
    #1300;
    check(long_gaps == 1, {req, " R1 one mute gap"}, long_gaps, 1);
    check(gap_len >= 300.0, "R2 low hold length", gap_len, 300.0);
    check((gap_end > tt) && (gap_end - tt <= 1000.0), "R3 settle", gap_end - tt, 1000.0);
    check_period({req, " R4 source after mute"});
  endtask

  initial begin
    realtime tr;
    realtime t1;
    realtime t2;
    real     p;
    int      bad;
    void'($urandom(32'd5813));

    // R8 reset state
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk_ref);
      if (i > 4 && out0 !== 1'b0) bad++;
    end
    check(bad == 0, "R8 low in reset", bad, 0);
    long_gaps = 0;
    rst = 1'b0;
    tr = $realtime;
    #1300;
    check(long_gaps == 1, "R8 single start", long_gaps, 1);
    check((gap_end - tr >= 450.0) && (gap_end - tr <= 1000.0), "R8 start after mute", gap_end - tr, 1000.0);
    check_period("R5 sel0 gives clk_a");
    meas1(p);
    check((p > 87.4) && (p < 88.6), "R7 fixed build clk_a", p, 88.0);

    // R1 both directions, R5 mapping
    switch_to(1'b1, 1'b0, "R5 rise");
    switch_to(1'b0, 1'b0, "R5 fall");
    switch_to(1'b0, 1'b1, "R5 swap");
    switch_to(1'b1, 1'b1, "R5 swap sel1");
    switch_to(1'b1, 1'b0, "R5 unswap");

    // R9 restart during mute
    long_gaps = 0;
    t1 = $realtime;
    sel = ~sel;
    #300;
    t2 = $realtime;
    sel = ~sel;
    #1400;
    check(gap_end - t2 >= 750.0, "R9 mute restarted", gap_end - t2, 750.0);
    check((gap_end - t2 <= 1000.0) && (gap_end > t1), "R9 settle after last", gap_end - t2, 1000.0);
    check_period("R9 final level");

    // random bursts
    for (int k = 0; k < 14; k++) begin
      int n;
      realtime tl;
      n = int'($urandom_range(1, 3));
      tl = $realtime;
      for (int j = 0; j < n; j++) begin
        #($urandom_range(30, 700));
        tl = $realtime;
        if ($urandom_range(0, 3) == 0) swap = ~swap;
        else sel = ~sel;
      end
      #1300;
      check((gap_end > tl) && (gap_end - tl <= 1000.0), "R3 random settle", gap_end - tl, 1000.0);
      check_period("R4 random final source");
    end
    check(runts == 0, "R2 no short pulses", runts, 0);

    // R6 strap off: no mute
    men = 1'b0;
    #400;
    runt_en = 1'b0;
    long_gaps = 0;
    sel = ~sel;
    #1300;
    check(long_gaps == 0, "R6 no gap", long_gaps, 0);
    check_period("R6 handover");
    long_gaps = 0;
    swap = ~swap;
    #1300;
    check(long_gaps == 0, "R6 no gap swap", long_gaps, 0);
    check_period("R6 handover swap");
    men = 1'b1;
    #400;
    runts = 0;
    runt_en = 1'b1;
    switch_to(~sel, swap, "R1 strap back on");
    check(runts == 0, "R2 no short pulses after strap", runts, 0);

    meas1(p);
    check((p > 87.4) && (p < 88.6), "R7 select ignored", p, 88.0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule